// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers six audio-codec event sources into one interrupt line. Five sources arrive as single-cycle pulses: short-circuit, headphone ramp-up done, headphone ramp-down done, gain-up done and gain-down done. The sixth source is derived inside the unit from any change of the jack-present level. Each event sets a sticky flag. Software clears a flag by writing a one to it. A mask register gates the flags, and its two upper bits choose the electrical form of the interrupt output.

The flag register also carries the live jack level as a read-only bit, so software can see the current plug state beside the latched change event. Two of the output forms are levels, one active-high and one active-low. The other two are one-cycle pulses, one active-high and one active-low.

A small state machine produces the pulse forms. It has three states:
- IDLE: no unmasked flag is pending.
- PULSE: the output is active for exactly one cycle.
- HOLD: the request is still present after the pulse.

Its transitions are:
- IDLE to PULSE when the combined request appears.
- PULSE to HOLD while the request remains.
- PULSE to IDLE when the request has gone.
- HOLD to IDLE when the request drops.

Top module: `codec_irq_ctrl`

## Requirements
- R1: After reset, all event flags read 0, the mask register reads 0x3F (every source masked, form 00), and `irq_o` is low.
- R2: A pulse on `src_evt_i[k]` sets flag bit k on the next clock edge, where bit 4 is short-circuit, bit 3 is ramp-up done, bit 2 is ramp-down done, bit 1 is gain-up done and bit 0 is gain-down done. The flag stays set after the pulse ends.
- R3: A write to the flag register (`wr_sel_i`=1) clears every flag bit written as 1 and leaves every bit written as 0 unchanged; writing 0x3F clears all six flags.
- R4: When an event and a clearing write hit the same flag bit in one cycle, the flag ends up set.
- R5: Flag bit 5 (jack event) sets on the edge after `jack_lvl_i` differs from its last sampled value, for both rising and falling changes; the sampled level resets to 0.
- R6: Flag register read (`rd_sel_i`=1) bit 6 shows the current `jack_lvl_i`, and bit 7 reads 0. Writes to bits 7:6 of the flag register have no effect.
- R7: The mask register (`wr_sel_i`=0) reads back what was written. A mask bit of 1 in bits 5:0 keeps the matching flag off the interrupt, and clearing the mask bit of a pending flag raises the interrupt.
- R8: Mask bits 7:6 set the form. With 00, `irq_o` is high while any unmasked flag is set. With 01, the output is the inverse: it is low while any unmasked flag is set.
- R9: With form 10 (high) or 11 (low), `irq_o` goes active for exactly one cycle, one cycle after the combined request appears. It gives no further pulse while the request stays present, and it is at its inactive level otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | 5 | Event pulses for flag bits 4..0 |
| jack_lvl_i | input | 1 | Jack-present level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 flag |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read source: 0 mask, 1 flag |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt output in the selected form |

## Verification
The bench aims at the collision of an event pulse with a clearing write. A design that lets the clear win would silently lose the event. It also checks partial clears and zero writes, which would wipe unrelated flags in a design that treats any flag write as a full clear. It follows the jack bit through both edges, and checks that bit 6 tracks the level rather than latching it. For the pulse forms, it counts the pulse cycle by cycle: a design that pulses on the level instead of the rising request would fire again when a second flag arrives, and a wrong inverse form would show the wrong idle level.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
    localparam int unsigned CIRQ_NUM_EVT = 6;
    localparam int unsigned CIRQ_REG_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } pulse_st_t;

    typedef enum logic [1:0] {
        FORM_LVL_HI   = 2'b00,
        FORM_LVL_LO   = 2'b01,
        FORM_PULSE_HI = 2'b10,
        FORM_PULSE_LO = 2'b11
    } irq_form_t;
endpackage

// File: rtl/cirq_flag_bank.sv
module cirq_flag_bank #(
    parameter int unsigned NUM_EVT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-2:0] src_evt,
    input  logic               jack_lvl,
    input  logic               clr_we,
    input  logic [NUM_EVT-1:0] clr_bits,
    output logic [NUM_EVT-1:0] flags
);
    logic               jack_q;
    logic [NUM_EVT-1:0] set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) jack_q <= 1'b0;
        else        jack_q <= jack_lvl;
    end

    assign set_vec = {jack_q ^ jack_lvl, src_evt};

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
                flags[i] <= 1'b0;
        end

        // R2 / R5: a set source leaves the flag set on the next cycle
        a_r2_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags[i]);
        // R3: clearing write without a competing event drops the flag
        a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && !set_vec[i]) |=> !flags[i]);
        // R3: a flag never rises without a source
        a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !set_vec[i]) |=> !flags[i]);
        // R4: event beats a same-cycle clear
        a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[i] && set_vec[i]) |=> flags[i]);
    end
endmodule

// File: rtl/cirq_mask_reg.sv
module cirq_mask_reg #(
    parameter int unsigned       REG_W   = 8,
    parameter logic [REG_W-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= wdata;
    end

    // R7: the mask register holds the last written value
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(wdata));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/cirq_out_fsm.sv
module cirq_out_fsm
    import codec_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  irq_form_t form,
    output logic      irq
);
    pulse_st_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ST_PULSE;
            ST_PULSE: state_nx = req ? ST_HOLD : ST_IDLE;
            ST_HOLD:  if (!req) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (form)
            FORM_LVL_HI:   irq = req;
            FORM_LVL_LO:   irq = !req;
            FORM_PULSE_HI: irq = (state == ST_PULSE);
            FORM_PULSE_LO: irq = (state != ST_PULSE);
            default:       irq = 1'b0;
        endcase
    end

    // R9: a pulse lasts one cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |=> (state != ST_PULSE));
    // R9: a pulse only follows an idle period with a new request
    a_r9_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULSE) |-> ($past(state) == ST_IDLE && $past(req)));
    // R9: no pulse while the request persists in HOLD
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && req) |=> (state == ST_HOLD));
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
    import codec_irq_pkg::*;
#(
    parameter int unsigned NUM_EVT  = CIRQ_NUM_EVT,
    parameter int unsigned REG_W    = CIRQ_REG_W,
    parameter logic [7:0]  MASK_RST = 8'h3F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-2:0] src_evt_i,
    input  logic               jack_lvl_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic               rd_sel_i,
    output logic [REG_W-1:0]   rd_data_o,
    output logic               irq_o
);
    localparam int unsigned LIVE_BIT = NUM_EVT;
    localparam int unsigned FORM_LSB = REG_W - 2;

    logic [NUM_EVT-1:0] flags;
    logic [REG_W-1:0]   mask_q;
    logic               req;
    irq_form_t          form;

    cirq_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt_i),
        .jack_lvl (jack_lvl_i),
        .clr_we   (wr_en_i && wr_sel_i),
        .clr_bits (wr_data_i[NUM_EVT-1:0]),
        .flags    (flags)
    );

    cirq_mask_reg #(.REG_W(REG_W), .RST_VAL(MASK_RST[REG_W-1:0])) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en_i && !wr_sel_i),
        .wdata (wr_data_i),
        .q     (mask_q)
    );

    assign req  = |(flags & ~mask_q[NUM_EVT-1:0]);
    assign form = irq_form_t'(mask_q[FORM_LSB +: 2]);

    cirq_out_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .form  (form),
        .irq   (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i) begin
            rd_data_o[NUM_EVT-1:0] = flags;
            rd_data_o[LIVE_BIT]    = jack_lvl_i;
        end else begin
            rd_data_o = mask_q;
        end
    end

    // R7: with every source masked, a level-high form never interrupts
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == {2'b00, {(REG_W-2){1'b1}}}) |-> !irq_o);
    // R6: flag read never shows bit 7
    a_r6_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_i |-> !rd_data_o[REG_W-1]);
endmodule

// File: tb/tb_codec_irq_ctrl.sv
module tb_codec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_evt_i = '0;
    logic       jack_lvl_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       rd_sel_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    codec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt_i), .jack_lvl_i(jack_lvl_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel_i = sel;
        #0.5;
        v = rd_data_o;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] b);
        @(negedge clk);
        src_evt_i = b;
        @(negedge clk);
        src_evt_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v); check("R1 mask reset", v, 8'h3F);
        rd(1'b1, v); check("R1 flags reset", v, 8'h00);
        check("R1 irq reset", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_set_each();
        logic [7:0] v;
        wr(1'b0, 8'h00);
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            rd(1'b1, v); check("R2 flag set", v, 8'(1 << i));
            check("R8 irq high level", {7'd0, irq_o}, 8'h01);
            wr(1'b1, 8'h3F);
            rd(1'b1, v); check("R3 clear all", v, 8'h00);
        end
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        pulse(5'h1F);
        rd(1'b1, v); check("R2 all flags", v, 8'h1F);
        wr(1'b1, 8'h05);
        rd(1'b1, v); check("R3 partial clear", v, 8'h1A);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R3 zero write", v, 8'h1A);
        wr(1'b1, 8'h3F);
        rd(1'b1, v); check("R3 full clear", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pulse(5'h01);
        @(negedge clk);
        src_evt_i = 5'h04; wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 8'h05;
        @(negedge clk);
        src_evt_i = '0; wr_en_i = 1'b0;
        rd(1'b1, v); check("R4 event wins", v, 8'h04);
        wr(1'b1, 8'h3F);
    endtask

    task automatic t_jack();
        logic [7:0] v;
        @(negedge clk); jack_lvl_i = 1'b1;
        @(negedge clk);
        rd(1'b1, v); check("R5 rising jack", v, 8'h60);
        wr(1'b1, 8'h20);
        rd(1'b1, v); check("R6 live bit stays", v, 8'h40);
        wr(1'b1, 8'hC0);
        rd(1'b1, v); check("R6 upper write ignored", v, 8'h40);
        @(negedge clk); jack_lvl_i = 1'b0;
        @(negedge clk);
        rd(1'b1, v); check("R5 falling jack", v, 8'h20);
        wr(1'b1, 8'h3F);
        rd(1'b1, v); check("R6 cleared", v, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(1'b0, 8'h3F);
        pulse(5'h08);
        rd(1'b1, v); check("R7 masked flag latched", v, 8'h08);
        check("R7 masked irq", {7'd0, irq_o}, 8'h00);
        wr(1'b0, 8'h37);
        rd(1'b0, v); check("R7 mask readback", v, 8'h37);
        check("R7 unmask raises", {7'd0, irq_o}, 8'h01);
        wr(1'b0, 8'h3F);
        check("R7 remask", {7'd0, irq_o}, 8'h00);
        wr(1'b1, 8'h3F);
    endtask

    task automatic t_levels();
        logic [7:0] v;
        wr(1'b0, 8'h40);
        rd(1'b0, v); check("R8 form readback", v, 8'h40);
        check("R8 low form idle", {7'd0, irq_o}, 8'h01);
        pulse(5'h02);
        check("R8 low form active", {7'd0, irq_o}, 8'h00);
        wr(1'b1, 8'h3F);
        check("R8 low form cleared", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_pulse();
        wr(1'b0, 8'h80);
        check("R9 high pulse idle", {7'd0, irq_o}, 8'h00);
        pulse(5'h01);
        check("R9 before pulse", {7'd0, irq_o}, 8'h00);
        @(negedge clk); check("R9 pulse cycle", {7'd0, irq_o}, 8'h01);
        @(negedge clk); check("R9 pulse ends", {7'd0, irq_o}, 8'h00);
        pulse(5'h02);
        @(negedge clk); check("R9 no repulse", {7'd0, irq_o}, 8'h00);
        wr(1'b1, 8'h3F);
        wr(1'b0, 8'hC0);
        @(negedge clk);
        check("R9 low pulse idle", {7'd0, irq_o}, 8'h01);
        pulse(5'h10);
        check("R9 low before pulse", {7'd0, irq_o}, 8'h01);
        @(negedge clk); check("R9 low pulse cycle", {7'd0, irq_o}, 8'h00);
        @(negedge clk); check("R9 low pulse ends", {7'd0, irq_o}, 8'h01);
        wr(1'b1, 8'h3F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_each();
        t_w1c();
        t_collide();
        t_jack();
        t_mask();
        t_levels();
        t_pulse();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule